// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block is the control state machine that carries a device from one life-cycle state to the next. It waits in an idle state until a transition is requested. It then runs a fixed sequence:

- switch the clock source;
- bump the transition counter and write it back;
- check that the requested move is legal;
- have the unlock token hashed and compare the result twice against the expected value;
- optionally run a flash-wipe handshake;
- write the target state.

Every failure along the way ends in one terminal "done" state, with a sticky error flag that says which step failed. Two escalation inputs push the machine into a terminal escalation state. An invalid incoming life-cycle state is trapped, and so is a corrupted state register.

The hash engine, the non-volatile counter and state storage, and the clock switch are outside the block. Each one is reached through a request/acknowledge pair. The block holds a request high until the acknowledge arrives and samples the matching error input in that same cycle. The state register uses sparse 16-bit codes, and any value that is not one of the fifteen legal codes is caught.

Top module: `lc_xfer_fsm`

## Requirements
- R1: While `rst_ni` is low, every output is 0. One clock after `rst_ni` rises, the machine is in idle (`idle_o`=1) whatever the other inputs are, and it stays in idle until the first cycle in which it evaluates its idle inputs.
- R2: In idle, the inputs are evaluated with this priority, and the resulting state is taken at the next clock:
  - `lc_valid_i`=0 enters the invalid state (`invalid_o`);
  - otherwise `scrap_i`=1 enters the scrap state (`scrap_o`);
  - otherwise `req_i`=1 enters the clock-switch step;
  - with none of these, the machine stays in idle.
- R3: In the clock-switch step, `clk_req_o` stays high until `clk_ack_i`, and the machine then moves to the counter-increment step. In that step, `cnt_sat_i`=1 ends in done with `cnt_err_o` set; otherwise the machine moves to the counter-program step.
- R4: In the counter-program step, `cnt_req_o` stays high until `cnt_ack_i`. On the acknowledge, `cnt_err_i`=1 ends in done with `cnt_err_o` set; otherwise the machine moves to the legality check.
- R5: In the legality check, `trans_ok_i`=1 moves to the hash step; otherwise the machine ends in done with `trans_err_o` set.
- R6: In the hash step, `hash_req_o` stays high until `hash_ack_i`. On the acknowledge:
  - `hash_err_i`=1 ends in done with `tok_err_o` set;
  - otherwise `hash_tok_i` is stored and the machine moves to the flash-wipe step.
- R7: In the flash-wipe step, `rma_req_o` equals `rma_sel_i`. The machine moves to the first token check either when `rma_sel_i`=0 or when `rma_ack_i`=1.
- R8: The stored token is compared with `exp_tok_i` in two consecutive checks, each lasting exactly one cycle. A mismatch in either check ends in done with `tok_err_o` set. A match in both moves to the program step.
- R9: In the program step, `prog_req_o`=1 and `prog_target_o`=`target_i` (`prog_target_o` is 0 in every other state) until `prog_ack_i`. On the acknowledge, the machine ends in done, and `prog_err_o` is set if `prog_err_i`=1.
- R10: Done, scrap and escalation are terminal. The status outputs `idle_o`, `done_o`, `scrap_o`, `esc_o`, `invalid_o` and the request outputs are mutually exclusive. The error flags are sticky until reset.
- R11: When `esc0_i` or `esc1_i` is high, the next clock enters the escalation state (`esc_o`). This applies from idle, from every sequence step, from done and from invalid. It does not apply in the reset state or in scrap. The cycle that escalates sets no error flag and stores no token.
- R12: The state register holds codes of the form {i, i^4'hA, ~i, i^4'h5} for indices i=0..14, so any two codes differ in at least 4 bits. Any other value moves the machine to the invalid state at the next clock and sets the sticky `state_err_o`, and this overrides escalation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| lc_valid_i | input | 1 | Incoming life-cycle state is a valid encoding |
| scrap_i | input | 1 | Scrap condition, evaluated in idle |
| req_i | input | 1 | Transition request, evaluated in idle |
| clk_ack_i | input | 1 | Clock switch done |
| cnt_sat_i | input | 1 | Transition counter saturated |
| cnt_ack_i | input | 1 | Counter write done |
| cnt_err_i | input | 1 | Counter write failed (sampled with ack) |
| trans_ok_i | input | 1 | Requested transition is legal |
| hash_ack_i | input | 1 | Token hash done |
| hash_err_i | input | 1 | Token hash failed (sampled with ack) |
| hash_tok_i | input | TokW | Hashed token |
| rma_sel_i | input | 1 | Flash-wipe handshake wanted |
| rma_ack_i | input | 1 | Flash wipe done |
| exp_tok_i | input | TokW | Expected hashed token |
| target_i | input | TgtW | Target life-cycle state to write |
| prog_ack_i | input | 1 | State write done |
| prog_err_i | input | 1 | State write failed (sampled with ack) |
| clk_req_o | output | 1 | Clock switch request |
| cnt_req_o | output | 1 | Counter write request |
| hash_req_o | output | 1 | Token hash request |
| rma_req_o | output | 1 | Flash wipe request |
| prog_req_o | output | 1 | State write request |
| prog_target_o | output | TgtW | State value to write |
| idle_o | output | 1 | In idle |
| done_o | output | 1 | In terminal done state |
| scrap_o | output | 1 | In scrap state |
| esc_o | output | 1 | In escalation state |
| invalid_o | output | 1 | In invalid state |
| cnt_err_o | output | 1 | Sticky counter error |
| trans_err_o | output | 1 | Sticky illegal-transition error |
| tok_err_o | output | 1 | Sticky hash or token error |
| prog_err_o | output | 1 | Sticky state-write error |
| state_err_o | output | 1 | Sticky illegal state-code error |

## Verification
The bench builds the block with an 8-bit token and a 4-bit target. With the narrow token, a mismatch of a single bit in any position can be drawn cheaply, and the value the bench expects for every stored token stays easy to follow. With the short target, every value written is compared in full. These settings, together with many short episodes that each start with a reset, bring every step's exit within reach: each acknowledge, error, escalation and trap path appears many times. A directed case corrupts the state code to reach the trap.

// File: rtl/lc_xfer_pkg.sv
package lc_xfer_pkg;

    localparam int StW   = 16;
    localparam int NumSt = 15;

    typedef logic [StW-1:0] st_t;

    typedef enum logic [3:0] {
        IxReset, IxIdle, IxClk, IxCntInc, IxCntProg, IxTransChk, IxHash,
        IxRma, IxTok0, IxTok1, IxProg, IxPost, IxScrap, IxEsc, IxInvalid
    } st_ix_e;

    // Four nibbles derived from the index: distinct indices differ in >= 4 bits.
    function automatic st_t st_code(input logic [3:0] idx);
        return {idx, idx ^ 4'hA, ~idx, idx ^ 4'h5};
    endfunction

    localparam st_t ST_RESET = st_code(IxReset);

    typedef struct packed {
        logic cnt;
        logic trans;
        logic tok;
        logic prog;
        logic state;
    } err_t;

endpackage

// File: rtl/lc_xfer_decode.sv
module lc_xfer_decode
    import lc_xfer_pkg::*;
(
    input  st_t    code_i,
    output st_ix_e ix_o,
    output logic   legal_o
);
    logic [NumSt-1:0] hit;

    for (genvar g = 0; g < NumSt; g++) begin : g_cmp
        assign hit[g] = (code_i == st_code(4'(g)));
    end

    always_comb begin
        ix_o = IxInvalid;
        for (int k = 0; k < NumSt; k++) begin
            if (hit[k]) ix_o = st_ix_e'(4'(k));
        end
    end

    assign legal_o = |hit;

endmodule

// File: rtl/lc_xfer_next.sv
module lc_xfer_next
    import lc_xfer_pkg::*;
(
    input  st_ix_e ix_i,
    input  logic   legal_i,
    input  logic   esc_i,
    input  logic   lc_valid_i,
    input  logic   scrap_i,
    input  logic   req_i,
    input  logic   clk_ack_i,
    input  logic   cnt_sat_i,
    input  logic   cnt_ack_i,
    input  logic   cnt_err_i,
    input  logic   trans_ok_i,
    input  logic   hash_ack_i,
    input  logic   hash_err_i,
    input  logic   rma_sel_i,
    input  logic   rma_ack_i,
    input  logic   tok_eq_i,
    input  logic   prog_ack_i,
    input  logic   prog_err_i,
    output st_ix_e nxt_o,
    output err_t   err_o,
    output logic   tok_load_o
);
    always_comb begin
        nxt_o      = ix_i;
        err_o      = '0;
        tok_load_o = 1'b0;
        case (ix_i)
            IxReset: nxt_o = IxIdle;
            IxIdle: begin
                if (!lc_valid_i)  nxt_o = IxInvalid;
                else if (scrap_i) nxt_o = IxScrap;
                else if (req_i)   nxt_o = IxClk;
            end
            IxClk: if (clk_ack_i) nxt_o = IxCntInc;
            IxCntInc: begin
                if (cnt_sat_i) begin
                    nxt_o     = IxPost;
                    err_o.cnt = 1'b1;
                end else begin
                    nxt_o = IxCntProg;
                end
            end
            IxCntProg: begin
                if (cnt_ack_i) begin
                    nxt_o     = cnt_err_i ? IxPost : IxTransChk;
                    err_o.cnt = cnt_err_i;
                end
            end
            IxTransChk: begin
                nxt_o       = trans_ok_i ? IxHash : IxPost;
                err_o.trans = !trans_ok_i;
            end
            IxHash: begin
                if (hash_ack_i) begin
                    nxt_o      = hash_err_i ? IxPost : IxRma;
                    err_o.tok  = hash_err_i;
                    tok_load_o = !hash_err_i;
                end
            end
            IxRma: if (!rma_sel_i || rma_ack_i) nxt_o = IxTok0;
            IxTok0: begin
                nxt_o     = tok_eq_i ? IxTok1 : IxPost;
                err_o.tok = !tok_eq_i;
            end
            IxTok1: begin
                nxt_o     = tok_eq_i ? IxProg : IxPost;
                err_o.tok = !tok_eq_i;
            end
            IxProg: begin
                if (prog_ack_i) begin
                    nxt_o      = IxPost;
                    err_o.prog = prog_err_i;
                end
            end
            default: nxt_o = ix_i;
        endcase

        if (esc_i && ix_i != IxReset && ix_i != IxScrap && ix_i != IxEsc) begin
            nxt_o      = IxEsc;
            err_o      = '0;
            tok_load_o = 1'b0;
        end

        if (!legal_i) begin
            nxt_o       = IxInvalid;
            err_o       = '0;
            err_o.state = 1'b1;
            tok_load_o  = 1'b0;
        end
    end

endmodule

// File: rtl/lc_xfer_fsm.sv
module lc_xfer_fsm
    import lc_xfer_pkg::*;
#(
    parameter int TokW = 32,
    parameter int TgtW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            esc0_i,
    input  logic            esc1_i,
    input  logic            lc_valid_i,
    input  logic            scrap_i,
    input  logic            req_i,
    input  logic            clk_ack_i,
    input  logic            cnt_sat_i,
    input  logic            cnt_ack_i,
    input  logic            cnt_err_i,
    input  logic            trans_ok_i,
    input  logic            hash_ack_i,
    input  logic            hash_err_i,
    input  logic [TokW-1:0] hash_tok_i,
    input  logic            rma_sel_i,
    input  logic            rma_ack_i,
    input  logic [TokW-1:0] exp_tok_i,
    input  logic [TgtW-1:0] target_i,
    input  logic            prog_ack_i,
    input  logic            prog_err_i,
    output logic            clk_req_o,
    output logic            cnt_req_o,
    output logic            hash_req_o,
    output logic            rma_req_o,
    output logic            prog_req_o,
    output logic [TgtW-1:0] prog_target_o,
    output logic            idle_o,
    output logic            done_o,
    output logic            scrap_o,
    output logic            esc_o,
    output logic            invalid_o,
    output logic            cnt_err_o,
    output logic            trans_err_o,
    output logic            tok_err_o,
    output logic            prog_err_o,
    output logic            state_err_o
);
    typedef struct packed {
        err_t            err;
        logic [TokW-1:0] tok;
    } dat_t;

    st_t    state_d, state_q, state_seen;
    dat_t   dat_d, dat_q;
    st_ix_e cur_ix, nxt_ix;
    logic   state_legal, tok_load;
    err_t   err_set;

    assign state_seen = state_q;

    lc_xfer_decode u_dec (
        .code_i  (state_seen),
        .ix_o    (cur_ix),
        .legal_o (state_legal)
    );

    lc_xfer_next u_nxt (
        .ix_i       (cur_ix),
        .legal_i    (state_legal),
        .esc_i      (esc0_i | esc1_i),
        .lc_valid_i (lc_valid_i),
        .scrap_i    (scrap_i),
        .req_i      (req_i),
        .clk_ack_i  (clk_ack_i),
        .cnt_sat_i  (cnt_sat_i),
        .cnt_ack_i  (cnt_ack_i),
        .cnt_err_i  (cnt_err_i),
        .trans_ok_i (trans_ok_i),
        .hash_ack_i (hash_ack_i),
        .hash_err_i (hash_err_i),
        .rma_sel_i  (rma_sel_i),
        .rma_ack_i  (rma_ack_i),
        .tok_eq_i   (dat_q.tok == exp_tok_i),
        .prog_ack_i (prog_ack_i),
        .prog_err_i (prog_err_i),
        .nxt_o      (nxt_ix),
        .err_o      (err_set),
        .tok_load_o (tok_load)
    );

    always_comb begin
        state_d   = st_code(nxt_ix);
        dat_d     = dat_q;
        dat_d.err = dat_q.err | err_set;
        if (tok_load) dat_d.tok = hash_tok_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RESET;
            dat_q   <= '0;
        end else begin
            state_q <= state_d;
            dat_q   <= dat_d;
        end
    end

    assign clk_req_o     = (cur_ix == IxClk);
    assign cnt_req_o     = (cur_ix == IxCntProg);
    assign hash_req_o    = (cur_ix == IxHash);
    assign rma_req_o     = (cur_ix == IxRma) && rma_sel_i;
    assign prog_req_o    = (cur_ix == IxProg);
    assign prog_target_o = (cur_ix == IxProg) ? target_i : '0;
    assign idle_o        = (cur_ix == IxIdle);
    assign done_o        = (cur_ix == IxPost);
    assign scrap_o       = (cur_ix == IxScrap);
    assign esc_o         = (cur_ix == IxEsc);
    assign invalid_o     = (cur_ix == IxInvalid);
    assign cnt_err_o     = dat_q.err.cnt;
    assign trans_err_o   = dat_q.err.trans;
    assign tok_err_o     = dat_q.err.tok;
    assign prog_err_o    = dat_q.err.prog;
    assign state_err_o   = dat_q.err.state;

endmodule

// File: rtl/lc_xfer_fsm_chk.sv
module lc_xfer_fsm_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic esc0_i,
    input logic esc1_i,
    input logic legal_i,
    input logic clk_ack_i,
    input logic cnt_ack_i,
    input logic cnt_err_i,
    input logic hash_ack_i,
    input logic prog_ack_i,
    input logic clk_req_o,
    input logic cnt_req_o,
    input logic hash_req_o,
    input logic prog_req_o,
    input logic idle_o,
    input logic done_o,
    input logic scrap_o,
    input logic esc_o,
    input logic invalid_o,
    input logic cnt_err_o,
    input logic state_err_o
);
    logic quiet;
    assign quiet = legal_i && !esc0_i && !esc1_i;

    assert_clk_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet && clk_req_o && !clk_ack_i |=> clk_req_o);

    assert_cnt_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet && cnt_req_o && cnt_ack_i && cnt_err_i |=> done_o && cnt_err_o);

    assert_hash_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet && hash_req_o && !hash_ack_i |=> hash_req_o);

    assert_prog_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet && prog_req_o && !prog_ack_i |=> prog_req_o);

    assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet && done_o |=> done_o);

    assert_scrap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legal_i && scrap_o |=> scrap_o);

    assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({idle_o, done_o, scrap_o, esc_o, invalid_o,
                  clk_req_o, cnt_req_o, hash_req_o, prog_req_o}));

    assert_esc_enter_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legal_i && (esc0_i || esc1_i) &&
        (idle_o || done_o || invalid_o || clk_req_o || cnt_req_o || hash_req_o || prog_req_o)
        |=> esc_o);

    assert_esc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legal_i && esc_o |=> esc_o);

    assert_trap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !legal_i |=> invalid_o && state_err_o);

endmodule

bind lc_xfer_fsm lc_xfer_fsm_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .esc0_i      (esc0_i),
    .esc1_i      (esc1_i),
    .legal_i     (state_legal),
    .clk_ack_i   (clk_ack_i),
    .cnt_ack_i   (cnt_ack_i),
    .cnt_err_i   (cnt_err_i),
    .hash_ack_i  (hash_ack_i),
    .prog_ack_i  (prog_ack_i),
    .clk_req_o   (clk_req_o),
    .cnt_req_o   (cnt_req_o),
    .hash_req_o  (hash_req_o),
    .prog_req_o  (prog_req_o),
    .idle_o      (idle_o),
    .done_o      (done_o),
    .scrap_o     (scrap_o),
    .esc_o       (esc_o),
    .invalid_o   (invalid_o),
    .cnt_err_o   (cnt_err_o),
    .state_err_o (state_err_o)
);

// File: tb/test_lc_xfer_fsm.sv
`timescale 1ns/1ps
module test_lc_xfer_fsm;
    localparam int TokW = 8;
    localparam int TgtW = 4;

    typedef enum int {MRst, MIdle, MClk, MCi, MCp, MTc, MHash, MRma, MT0, MT1,
                      MProg, MPost, MScrap, MEsc, MInv} m_e;

    logic clk = 1'b0, rst_n = 1'b0;
    logic esc0, esc1, lc_valid, scrap, req, clk_ack, cnt_sat, cnt_ack, cnt_err;
    logic trans_ok, hash_ack, hash_err, rma_sel, rma_ack, prog_ack, prog_err;
    logic [TokW-1:0] hash_tok, exp_tok;
    logic [TgtW-1:0] target, prog_target;
    logic clk_req, cnt_req, hash_req, rma_req, prog_req;
    logic idle, done, scrapd, escd, invd, e_cnt, e_trans, e_tok, e_prog, e_state;

    int total = 0, bad = 0;
    bit finished = 0;

    m_e m_st;
    logic [TokW-1:0] m_tok;
    logic [4:0] m_err; // cnt, trans, tok, prog, state

    always #4 clk = ~clk;

    lc_xfer_fsm #(.TokW(TokW), .TgtW(TgtW)) i_lc_xfer_fsm (
        .clk_i(clk), .rst_ni(rst_n), .esc0_i(esc0), .esc1_i(esc1),
        .lc_valid_i(lc_valid), .scrap_i(scrap), .req_i(req), .clk_ack_i(clk_ack),
        .cnt_sat_i(cnt_sat), .cnt_ack_i(cnt_ack), .cnt_err_i(cnt_err),
        .trans_ok_i(trans_ok), .hash_ack_i(hash_ack), .hash_err_i(hash_err),
        .hash_tok_i(hash_tok), .rma_sel_i(rma_sel), .rma_ack_i(rma_ack),
        .exp_tok_i(exp_tok), .target_i(target), .prog_ack_i(prog_ack),
        .prog_err_i(prog_err), .clk_req_o(clk_req), .cnt_req_o(cnt_req),
        .hash_req_o(hash_req), .rma_req_o(rma_req), .prog_req_o(prog_req),
        .prog_target_o(prog_target), .idle_o(idle), .done_o(done),
        .scrap_o(scrapd), .esc_o(escd), .invalid_o(invd), .cnt_err_o(e_cnt),
        .trans_err_o(e_trans), .tok_err_o(e_tok), .prog_err_o(e_prog),
        .state_err_o(e_state)
    );

    function automatic string tag_of(m_e s);
        case (s)
            MRst: return "R1";   MIdle: return "R2";  MClk, MCi: return "R3";
            MCp: return "R4";    MTc: return "R5";    MHash: return "R6";
            MRma: return "R7";   MT0, MT1: return "R8"; MProg: return "R9";
            MPost, MScrap: return "R10"; MEsc: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [18:0] exp_outs();
        logic [18:0] v;
        v = {m_st == MClk, m_st == MCp, m_st == MHash, (m_st == MRma) && rma_sel,
             m_st == MProg, m_st == MIdle, m_st == MPost, m_st == MScrap,
             m_st == MEsc, m_st == MInv, m_err,
             (m_st == MProg) ? target : {TgtW{1'b0}}};
        return v;
    endfunction

    function automatic logic [18:0] act_outs();
        return {clk_req, cnt_req, hash_req, rma_req, prog_req, idle, done, scrapd,
                escd, invd, e_cnt, e_trans, e_tok, e_prog, e_state, prog_target};
    endfunction

    task automatic check(string tag, logic [18:0] act, logic [18:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        m_e n = m_st;
        logic [4:0] es = '0;
        logic ld = 1'b0;
        logic eq = (m_tok == exp_tok);
        case (m_st)
            MRst: n = MIdle;
            MIdle: n = !lc_valid ? MInv : scrap ? MScrap : req ? MClk : MIdle;
            MClk: if (clk_ack) n = MCi;
            MCi: begin n = cnt_sat ? MPost : MCp; es[4] = cnt_sat; end
            MCp: if (cnt_ack) begin n = cnt_err ? MPost : MTc; es[4] = cnt_err; end
            MTc: begin n = trans_ok ? MHash : MPost; es[3] = !trans_ok; end
            MHash: if (hash_ack) begin
                n = hash_err ? MPost : MRma; es[2] = hash_err; ld = !hash_err;
            end
            MRma: if (!rma_sel || rma_ack) n = MT0;
            MT0: begin n = eq ? MT1 : MPost; es[2] = !eq; end
            MT1: begin n = eq ? MProg : MPost; es[2] = !eq; end
            MProg: if (prog_ack) begin n = MPost; es[1] = prog_err; end
            default: n = m_st;
        endcase
        if ((esc0 || esc1) && !(m_st inside {MRst, MScrap, MEsc})) begin
            n = MEsc; es = '0; ld = 1'b0;
        end
        if (ld) m_tok = hash_tok;
        m_err = m_err | es;
        m_st = n;
    endtask

    task automatic quiet();
        esc0 = 0; esc1 = 0; lc_valid = 1; scrap = 0; req = 0; clk_ack = 0;
        cnt_sat = 0; cnt_ack = 0; cnt_err = 0; trans_ok = 1; hash_ack = 0;
        hash_err = 0; rma_sel = 0; rma_ack = 0; prog_ack = 0; prog_err = 0;
        hash_tok = '0; exp_tok = '0; target = '0;
    endtask

    task automatic rnd_inputs();
        esc0 = ($urandom % 60) == 0; esc1 = ($urandom % 60) == 0;
        lc_valid = ($urandom % 30) != 0; scrap = ($urandom % 20) == 0;
        req = ($urandom % 3) == 0; clk_ack = $urandom % 2;
        cnt_sat = ($urandom % 8) == 0; cnt_ack = $urandom % 2;
        cnt_err = ($urandom % 8) == 0; trans_ok = ($urandom % 8) != 0;
        hash_ack = $urandom % 2; hash_err = ($urandom % 8) == 0;
        hash_tok = TokW'($urandom); rma_sel = $urandom % 2; rma_ack = $urandom % 2;
        prog_ack = $urandom % 2; prog_err = ($urandom % 4) == 0;
        target = TgtW'($urandom);
        exp_tok = (($urandom % 6) == 0) ? (m_tok ^ (TokW'(1) << ($urandom % TokW))) : m_tok;
    endtask

    // inputs already driven at a falling edge: check, advance model, wait one cycle
    task automatic cyc();
        #1;
        check(tag_of(m_st), act_outs(), exp_outs());
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", act_outs(), 19'h0); // R1: all outputs low in reset
        rst_n = 1;
        m_st = MRst; m_tok = '0; m_err = '0;
    endtask

    initial begin
        void'($urandom(32'h51A7E));
        quiet();
        @(negedge clk);

        // Directed: complete clean transition with flash wipe (R2..R9)
        do_reset();
        quiet(); req = 1; clk_ack = 1; cnt_ack = 1; hash_ack = 1; rma_sel = 1;
        rma_ack = 1; prog_ack = 1; hash_tok = 8'h5A; exp_tok = 8'h5A; target = 4'h9;
        repeat (14) cyc();

        // Directed: scrap is terminal and ignores escalation (R10, R11)
        do_reset();
        quiet(); scrap = 1; repeat (3) cyc();
        esc0 = 1; esc1 = 1; repeat (3) cyc();

        // Directed: escalation while waiting on the clock switch (R3, R11)
        do_reset();
        quiet(); req = 1; repeat (4) cyc();
        esc1 = 1; repeat (2) cyc();

        // Directed: corrupted state code from idle is trapped (R12)
        do_reset();
        quiet(); cyc(); cyc();
        force i_lc_xfer_fsm.state_seen = 16'h0000;
        @(posedge clk); #1;
        release i_lc_xfer_fsm.state_seen;
        m_st = MInv; m_err[0] = 1'b1;
        @(negedge clk);
        cyc();
        esc0 = 1; cyc(); cyc(); // R11: escalation from invalid

        // Random episodes
        for (int ep = 0; ep < 150; ep++) begin
            do_reset();
            for (int c = 0; c < 120; c++) begin
                rnd_inputs();
                if (m_st == MIdle && ($urandom % 2) == 0) begin
                    req = 1; scrap = 0; lc_valid = 1;
                end
                cyc();
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule